// File: doc/BRIEF.md
# Warm-Start CPU Reset Pulse Generator

This block drives the active-low reset line of an 8-bit processor with a Z80-style bus. Its input is a raw push-button. The button is synchronised and debounced, and each press turns into exactly one reset request. A mode input, read at the moment the request is taken, picks one of two reset types.

A cold reset holds the line low for a fixed number of clocks, so the whole processor restarts. A warm reset waits for an opcode fetch, which the block recognises as the fall of the fetch strobe. It then pulls the line low for exactly one clock, so only the program counter is cleared and any memory write in flight is left alone. If no fetch shows up within a bounded window, the block gives up and issues a cold reset instead.

A power-on input overrides everything and leads into a cold reset. All inputs are assumed synchronous to the CPU clock except the button. The fetch strobe is assumed to be presented so that its first low sample marks the start of T1.

Top module: `warm_reset_gen`

## Requirements
- R1: After a two-stage synchroniser, `btn_n` must stay low for DEB_CYCLES (default 16) consecutive clocks before a request is accepted. The acceptance edge is the (DEB_CYCLES+3)-th rising edge after `btn_n` falls. A low glitch shorter than that produces no reset.
- R2: With `warm_sel`=0 at acceptance, `cpu_rst_n` goes low at the acceptance edge and stays low for exactly COLD_CYCLES clocks (default 4, at least 3).
- R3: With `warm_sel`=1 at acceptance, `cpu_rst_n` goes low at the first later edge where `m1_n` is sampled 0 after being sampled 1 at the edge before. It returns high on the next edge, giving a single-clock low pulse.
- R4: A warm pulse needs a fresh fetch-strobe fall. If `m1_n` is already low and stays low, no single-clock pulse is produced.
- R5: If no qualifying fall of `m1_n` is seen at any of the M1_TIMEOUT (default 64) edges after a warm acceptance, a cold pulse of COLD_CYCLES clocks starts at the M1_TIMEOUT-th edge. A fall sampled at exactly that edge still yields the warm pulse.
- R6: The mode is taken from `warm_sel` at the acceptance edge only; later changes have no effect on the reset in progress.
- R7: While `por_n` is low, `cpu_rst_n` is low at once, without waiting for a clock, even in the middle of a warm reset. After `por_n` rises, `cpu_rst_n` stays low for COLD_CYCLES clocks counted from the rise.
- R8: One press yields one reset. A held button gives no further reset, and a press whose debounce completes while a reset is in progress is discarded.
- R9: `busy` is high from the acceptance edge up to the edge at which `cpu_rst_n` returns high. It is also high during and after power-on until that cold pulse ends. `cpu_rst_n` is high whenever `busy` is low and `por_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| por_n | input | 1 | Power-on reset, active low; forces the output low asynchronously and restarts the block synchronously |
| btn_n | input | 1 | Raw reset button, low when pressed, asynchronous |
| warm_sel | input | 1 | Reset type: 0 cold, 1 warm |
| m1_n | input | 1 | CPU opcode-fetch strobe, active low |
| cpu_rst_n | output | 1 | Reset to the CPU, active low |
| busy | output | 1 | High while an accepted reset is being produced |

## Verification
The hardest cases to reach sit at the edge of the fetch-wait window. One is a strobe fall landing on the very last edge of the window; the other is a fall landing one edge too late. Both are reached by releasing the strobe a computed number of falling clock edges after the acceptance edge, which is itself located exactly through the debounce latency. The second hard case is a new press while a reset is in progress. The bench gets there by releasing and re-pressing the button inside the long warm wait, so that the second debounce finishes before the window ends. A power-on assertion inside that same wait shows the override.

// File: rtl/rg_pkg.sv
// Shared types for the warm-start reset generator.
// Assumes nothing beyond a single clock domain for its users.
package rg_pkg;
    typedef enum logic [1:0] {
        RG_IDLE  = 2'd0,
        RG_COLD  = 2'd1,
        RG_WAIT  = 2'd2,
        RG_PULSE = 2'd3
    } rg_state_e;
endpackage

// File: rtl/rg_btn_filter.sv
// Button conditioner: two-flop synchroniser, stable-level debounce, and a
// one-clock press strobe on each released-to-pressed transition.
// Assumes btn_n is low when pressed and may bounce or be asynchronous.
module rg_btn_filter #(
    parameter int DEB_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_n,
    output logic press
);
    localparam int DW = $clog2(DEB_CYCLES + 1);
    localparam logic [DW-1:0] DEB_LAST = DW'(DEB_CYCLES - 1);

    logic          sync1_q, sync2_q;
    logic          level_q;
    logic [DW-1:0] stab_cnt_q;
    logic          press_q;

    // Synchronise, debounce and flag a new press.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q    <= 1'b1;
            sync2_q    <= 1'b1;
            level_q    <= 1'b1;
            stab_cnt_q <= '0;
            press_q    <= 1'b0;
        end else begin
            sync1_q <= btn_n;
            sync2_q <= sync1_q;
            press_q <= 1'b0;
            if (sync2_q == level_q) begin
                stab_cnt_q <= '0;
            end else if (stab_cnt_q == DEB_LAST) begin
                level_q    <= sync2_q;
                stab_cnt_q <= '0;
                press_q    <= ~sync2_q;
            end else begin
                stab_cnt_q <= stab_cnt_q + 1'b1;
            end
        end
    end

    assign press = press_q;

    // R1
    press_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        press_q |-> (!level_q && $past(level_q)));

    // R8
    no_repeat_press_chk: assert property (@(posedge clk) disable iff (!rst_n)
        press_q |=> !press_q);
endmodule

// File: rtl/rg_m1_edge.sv
// Fetch-strobe tracker: flags a clock whose m1_n sample is low while the
// previous sample was high, i.e. the start of an opcode fetch.
// Assumes m1_n is synchronous to clk; after reset a high sample is needed first.
module rg_m1_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic m1_n,
    output logic m1_fall
);
    logic m1_prev_q;

    // Remember the previous strobe sample.
    always_ff @(posedge clk) begin
        if (!rst_n) m1_prev_q <= 1'b0;
        else        m1_prev_q <= m1_n;
    end

    assign m1_fall = m1_prev_q & ~m1_n;
endmodule

// File: rtl/rg_pulse_fsm.sv
// Reset sequencer: on a request picks cold or warm mode, waits for a fetch
// in warm mode with a timeout fallback, and times the registered reset level.
// Assumes req is a one-clock strobe and m1_fall marks T1 of a fetch.
module rg_pulse_fsm
    import rg_pkg::*;
#(
    parameter int COLD_CYCLES = 4,
    parameter int M1_TIMEOUT  = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic warm_sel,
    input  logic m1_fall,
    output logic rst_out_n,
    output logic busy
);
    localparam int CMAX = (COLD_CYCLES > M1_TIMEOUT) ? COLD_CYCLES : M1_TIMEOUT;
    localparam int CW   = $clog2(CMAX + 1);
    localparam logic [CW-1:0] COLD_LAST = CW'(COLD_CYCLES - 1);
    localparam logic [CW-1:0] WAIT_LAST = CW'(M1_TIMEOUT - 1);

    rg_state_e     state_q;
    logic [CW-1:0] cnt_q;
    logic          rst_q;

    // Advance the sequence and drive the registered reset level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RG_COLD;
            cnt_q   <= '0;
            rst_q   <= 1'b0;
        end else begin
            unique case (state_q)
                RG_IDLE: begin
                    cnt_q <= '0;
                    if (req) begin
                        state_q <= warm_sel ? RG_WAIT : RG_COLD;
                        rst_q   <= warm_sel;
                    end
                end
                RG_COLD: begin
                    if (cnt_q == COLD_LAST) begin
                        state_q <= RG_IDLE;
                        rst_q   <= 1'b1;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                RG_WAIT: begin
                    if (m1_fall) begin
                        state_q <= RG_PULSE;
                        rst_q   <= 1'b0;
                    end else if (cnt_q == WAIT_LAST) begin
                        state_q <= RG_COLD;
                        rst_q   <= 1'b0;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                RG_PULSE: begin
                    state_q <= RG_IDLE;
                    rst_q   <= 1'b1;
                    cnt_q   <= '0;
                end
                default: begin
                    state_q <= RG_IDLE;
                    rst_q   <= 1'b1;
                end
            endcase
        end
    end

    assign rst_out_n = rst_q;
    assign busy      = (state_q != RG_IDLE);

    // R3
    warm_assert_on_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RG_WAIT && m1_fall) |=> !rst_q);

    // R3
    warm_single_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RG_PULSE) |=> (rst_q && state_q == RG_IDLE));

    // R2
    cold_min_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rst_q) && state_q == RG_COLD) |=> !rst_q ##1 !rst_q);

    // R5
    wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RG_WAIT) |-> (cnt_q < CW'(M1_TIMEOUT)));

    // R9
    idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> rst_q);

    // R8
    busy_ignores_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RG_WAIT && req && !m1_fall && cnt_q != WAIT_LAST) |=> (state_q == RG_WAIT));
endmodule

// File: rtl/warm_reset_gen.sv
// Top of the reset generator: conditions the button, tracks the fetch strobe
// and sequences cold or single-clock warm resets; por_n forces reset at once.
// Assumes clk is the CPU clock and m1_n, warm_sel are synchronous to it.
module warm_reset_gen #(
    parameter int DEB_CYCLES  = 16,
    parameter int COLD_CYCLES = 4,
    parameter int M1_TIMEOUT  = 64
) (
    input  logic clk,
    input  logic por_n,
    input  logic btn_n,
    input  logic warm_sel,
    input  logic m1_n,
    output logic cpu_rst_n,
    output logic busy
);
    logic press;
    logic m1_fall;
    logic seq_rst_n;

    rg_btn_filter #(.DEB_CYCLES(DEB_CYCLES)) u_btn (
        .clk   (clk),
        .rst_n (por_n),
        .btn_n (btn_n),
        .press (press)
    );

    rg_m1_edge u_m1 (
        .clk     (clk),
        .rst_n   (por_n),
        .m1_n    (m1_n),
        .m1_fall (m1_fall)
    );

    rg_pulse_fsm #(.COLD_CYCLES(COLD_CYCLES), .M1_TIMEOUT(M1_TIMEOUT)) u_seq (
        .clk       (clk),
        .rst_n     (por_n),
        .req       (press),
        .warm_sel  (warm_sel),
        .m1_fall   (m1_fall),
        .rst_out_n (seq_rst_n),
        .busy      (busy)
    );

    // Power-on overrides the sequencer without waiting for a clock.
    assign cpu_rst_n = seq_rst_n & por_n;

    // R9
    out_needs_busy_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!cpu_rst_n) |-> busy);
endmodule

// File: tb/tb_warm_reset_gen.sv
module tb_warm_reset_gen;
    localparam int DEB  = 16;
    localparam int COLD = 4;
    localparam int TOUT = 64;
    localparam int NV   = 10;
    // fields: [10] warm, [9] strobe low beforehand, [8] flip mode after accept, [7:0] fall delay (255 = never)
    localparam logic [10:0] VEC [NV] = '{
        {1'b0, 1'b0, 1'b0, 8'd255},
        {1'b1, 1'b0, 1'b0, 8'd0},
        {1'b1, 1'b0, 1'b0, 8'd5},
        {1'b1, 1'b0, 1'b0, 8'd62},
        {1'b1, 1'b0, 1'b0, 8'd63},
        {1'b1, 1'b0, 1'b0, 8'd64},
        {1'b1, 1'b1, 1'b0, 8'd255},
        {1'b1, 1'b0, 1'b1, 8'd3},
        {1'b0, 1'b0, 1'b1, 8'd2},
        {1'b1, 1'b0, 1'b0, 8'd255}
    };

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic btn_n = 1'b1;
    logic warm_sel = 1'b0;
    logic m1_n = 1'b1;
    logic cpu_rst_n, busy;
    int   checks = 0;
    int   errors = 0;
    int   cyc = 0;
    int   pre, lo;

    warm_reset_gen #(.DEB_CYCLES(DEB), .COLD_CYCLES(COLD), .M1_TIMEOUT(TOUT)) dut (
        .clk(clk), .por_n(por_n), .btn_n(btn_n), .warm_sel(warm_sel),
        .m1_n(m1_n), .cpu_rst_n(cpu_rst_n), .busy(busy)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            summary();
        end
    end

    // Press button and land on the falling edge right after acceptance (R1).
    task automatic press_accept();
        @(negedge clk) btn_n = 1'b0;
        repeat (DEB + 2) @(posedge clk);
        @(negedge clk);
        chk("R1 busy before acceptance edge", busy, 0);
        @(posedge clk);
        @(negedge clk);
        chk("R1 busy at acceptance edge", busy, 1);
    endtask

    // Count high then low samples of cpu_rst_n from the current falling edge.
    task automatic measure(output int p, output int l);
        p = 0;
        l = 0;
        for (int i = 0; i < 400; i++) begin
            if (cpu_rst_n && l == 0) p++;
            else if (!cpu_rst_n) l++;
            else break;
            @(negedge clk);
        end
        chk("R9 busy drops with release", busy, 0);
    endtask

    task automatic release_btn();
        @(negedge clk) btn_n = 1'b1;
        repeat (DEB + 6) @(negedge clk);
    endtask

    initial begin
        // Power-on state and cold release (R7, R9)
        repeat (4) @(negedge clk);
        chk("R7 reset low during power-on", cpu_rst_n, 0);
        chk("R9 busy during power-on", busy, 1);
        por_n = 1'b1;
        measure(pre, lo);
        chk("R7 post power-on low clocks", lo, COLD);
        chk("R7 no delay before low", pre, 0);

        // Vector table: mode, strobe timing, expected window and width
        for (int v = 0; v < NV; v++) begin
            logic warm, plow, flip;
            int d, ep, el;
            warm = VEC[v][10];
            plow = VEC[v][9];
            flip = VEC[v][8];
            d    = int'(VEC[v][7:0]);
            if (!warm) begin ep = 0; el = COLD; end                        // R2
            else if (!plow && d < TOUT) begin ep = d + 1; el = 1; end      // R3
            else begin ep = TOUT; el = COLD; end                           // R4 R5
            warm_sel = warm;
            m1_n = !plow;
            press_accept();
            fork
                measure(pre, lo);
                begin
                    if (flip) warm_sel = !warm_sel;                        // R6
                    if (d != 255) begin
                        repeat (d) @(negedge clk);
                        m1_n = 1'b0;
                        repeat (3) @(negedge clk);
                        m1_n = 1'b1;
                    end
                end
            join
            m1_n = 1'b1;
            chk($sformatf("R3 R5 R6 vec%0d cycles before low", v), pre, ep);
            chk($sformatf("R2 R3 R6 vec%0d low width", v), lo, el);
            // Held button gives no second reset (R8)
            repeat (30) @(negedge clk);
            chk("R8 held button no repeat", busy, 0);
            chk("R8 held button output high", cpu_rst_n, 1);
            release_btn();
        end

        // Bounce shorter than the debounce window (R1)
        @(negedge clk) btn_n = 1'b0;
        repeat (DEB - 2) @(negedge clk);
        btn_n = 1'b1;
        repeat (40) @(negedge clk);
        chk("R1 short glitch ignored", busy, 0);
        chk("R1 short glitch output high", cpu_rst_n, 1);

        // New press during a warm wait is discarded (R8)
        warm_sel = 1'b1;
        m1_n = 1'b1;
        press_accept();
        fork
            measure(pre, lo);
            begin
                btn_n = 1'b1;
                repeat (24) @(negedge clk);
                btn_n = 1'b0;
            end
        join
        chk("R8 re-press in wait timeout start", pre, TOUT);
        chk("R8 re-press in wait width", lo, COLD);
        repeat (40) @(negedge clk);
        chk("R8 discarded press gives no reset", busy, 0);
        release_btn();

        // Power-on during warm wait overrides at once (R7)
        warm_sel = 1'b1;
        press_accept();
        repeat (10) @(negedge clk);
        chk("R7 warm wait output high", cpu_rst_n, 1);
        por_n = 1'b0;
        btn_n = 1'b1;
        #0.5;
        chk("R7 immediate override", cpu_rst_n, 0);
        repeat (3) @(negedge clk);
        chk("R7 busy under power-on", busy, 1);
        por_n = 1'b1;
        measure(pre, lo);
        chk("R7 cold after override width", lo, COLD);
        repeat (DEB + 6) @(negedge clk);
        chk("R7 idle after override", busy, 0);

        summary();
    end
endmodule